// File: doc/BRIEF.md
# Escalating Multistage Watchdog

This block supervises a processor through a chain of timer stages. After reset it waits a programmable boot delay, then starts the first stage. The processor must keep restarting that first stage with a kick. If it stops, the first stage expires, raises its corrective-action level and hands control to the second stage. Each later stage runs its own interval and then escalates in the same way. Only the first stage listens to the kick. Once the escalation has begun, the processor cannot stop it. Only a reset of the block returns it to the start.

When the final stage expires, it raises its action level and also fires a reset pulse of fixed width. This pulse is issued once per escalation. A typical hook-up has three stages: stage 0 drives a non-maskable interrupt, stage 1 drives fail-safe outputs, and stage 2 together with the pulse resets the system. All stages share one down-counter and a stage index, and each interval is sampled at the moment its stage is loaded.

Top module: `escalation_watchdog`

## Requirements
- R1: While reset is held and until the first stage is loaded, every `stage_action` bit and `reset_pulse` are 0.
- R2: With D = `boot_delay`, the block loads stage 0 on the (D+2)-th rising edge after reset release. Kicks before that edge have no effect.
- R3: A stage loaded with interval I and not restarted times out I+1 edges after its load edge, and its `stage_action` bit rises on that edge.
- R4: While stage 0 runs, a kick reloads it with its interval on that edge. This holds even on the edge where the count has reached zero: the kick takes priority over the timeout.
- R5: When stage k (not the last) times out, stage k+1 is loaded with its own interval on that same edge.
- R6: Once stage 0 has timed out, kicks have no effect on any later stage or output.
- R7: Each `stage_action` bit stays 1 from its timeout until reset. Bit k is never 1 unless bits below k are 1.
- R8: On the final stage's timeout, `reset_pulse` goes high on that same edge for exactly PULSE_LEN cycles. No further stage starts, and the pulse does not recur until reset.
- R9: Stage k's interval is `stage_interval[k*CNT_W +: CNT_W]`, with stage 0 in the low bits. It is sampled only on that stage's load edge, and later changes do not affect the running stage.
- R10: An interval of 0 makes the stage time out on the edge after its load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Restart request for stage 0, one cycle per kick |
| boot_delay | input | BOOT_W | Cycles to wait after reset before arming |
| stage_interval | input | NUM_STAGES*CNT_W | Per-stage intervals, stage 0 in the low bits |
| stage_action | output | NUM_STAGES | Sticky corrective-action level per stage |
| reset_pulse | output | 1 | Fixed-width reset pulse from the final stage |

## Verification
The in-RTL assertions check on every cycle the following:
- the action levels stay set;
- escalation happens in order;
- the stage index never moves backwards;
- kicks leave later stages counting;
- no action appears before arming;
- the enable stays sticky;
- the pulse stays within PULSE_LEN cycles and fires only once per escalation.

Only the bench's scenarios can show the exact timing:
- the edge numbers of the arming, of each timeout and of each hand-off;
- a kick that rescues stage 0 on its zero count;
- an interval changed after its stage was loaded;
- zero-length intervals;
- a reset in the middle of an escalation.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic [1:0] {
      WD_IDLE = 2'd0,
      WD_RUN  = 2'd1,
      WD_DONE = 2'd2
   } wd_phase_t;
endpackage

// File: rtl/wdg_boot_gate.sv
module wdg_boot_gate #(
   parameter int BOOT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BOOT_W-1:0] delay,
   output logic              enabled
);
   logic [BOOT_W-1:0] wait_q;
   logic              en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= '0;
         en_q   <= 1'b0;
      end else if (!en_q) begin
         if (wait_q == delay) en_q <= 1'b1;
         else                 wait_q <= wait_q + 1'b1;
      end
   end

   assign enabled = en_q;

   // R2: once armed the gate never drops the enable before reset
   assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);
endmodule

// File: rtl/wdg_stage_seq.sv
module wdg_stage_seq
   import wdg_pkg::*;
#(
   parameter int NUM_STAGES = 3,
   parameter int CNT_W      = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        enable,
   input  logic                        kick,
   input  logic [NUM_STAGES*CNT_W-1:0] intervals,
   output logic [NUM_STAGES-1:0]       action,
   output logic                        final_fire
);
   localparam int IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;
   localparam int LAST  = NUM_STAGES - 1;

   logic [CNT_W-1:0] ivl [NUM_STAGES];
   for (genvar g = 0; g < NUM_STAGES; g++) begin : g_unpack
      assign ivl[g] = intervals[g*CNT_W +: CNT_W];
   end

   wd_phase_t            phase_q;
   logic [IDX_W-1:0]     stage_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [NUM_STAGES-1:0] act_q;

   logic             is_last;
   logic             first_kick;
   logic             expire;
   logic [IDX_W-1:0] next_idx;

   always_comb begin
      is_last    = (stage_q == IDX_W'(LAST));
      first_kick = kick && (stage_q == '0);
      expire     = (phase_q == WD_RUN) && !first_kick && (cnt_q == '0);
      next_idx   = is_last ? stage_q : IDX_W'(stage_q + 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= WD_IDLE;
         stage_q <= '0;
         cnt_q   <= '0;
         act_q   <= '0;
      end else begin
         case (phase_q)
            WD_IDLE: begin
               if (enable) begin
                  phase_q <= WD_RUN;
                  stage_q <= '0;
                  cnt_q   <= ivl[0];
               end
            end
            WD_RUN: begin
               if (first_kick) begin
                  cnt_q <= ivl[0];
               end else if (cnt_q == '0) begin
                  act_q[stage_q] <= 1'b1;
                  if (is_last) begin
                     phase_q <= WD_DONE;
                  end else begin
                     stage_q <= next_idx;
                     cnt_q   <= ivl[next_idx];
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign action     = act_q;
   assign final_fire = expire && is_last;

   // R7: action levels are sticky and escalate in order
   for (genvar a = 0; a < NUM_STAGES; a++) begin : g_chk
      assert_action_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
         act_q[a] |=> act_q[a]);
      if (a > 0) begin : g_order
         assert_action_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
            act_q[a] |-> act_q[a-1]);
      end
   end

   // R5: the stage index never moves backwards
   assert_stage_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != WD_IDLE) |=> (stage_q >= $past(stage_q)));

   // R6: a kick in a later stage leaves its count running down
   assert_late_kick_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == WD_RUN && stage_q != '0 && kick && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R1: no action before the sequencer leaves idle
   assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == WD_IDLE) |-> (act_q == '0));
endmodule

// File: rtl/wdg_pulse_gen.sv
module wdg_pulse_gen #(
   parameter int PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   localparam int LEN_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN + 1) : 1;

   if (PULSE_LEN == 1) begin : g_single
      logic p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) p_q <= 1'b0;
         else        p_q <= fire;
      end
      assign pulse = p_q;
   end else begin : g_counted
      logic [LEN_W-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              left_q <= '0;
         else if (fire)           left_q <= LEN_W'(PULSE_LEN);
         else if (left_q != '0)   left_q <= left_q - 1'b1;
      end
      assign pulse = (left_q != '0);
   end

   // R8: width check through an independent run-length counter
   int unsigned run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_len <= 0;
      else if (pulse) run_len <= run_len + 1;
      else            run_len <= 0;
   end

   assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= PULSE_LEN);
   assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse) |-> $past(fire));
endmodule

// File: rtl/escalation_watchdog.sv
module escalation_watchdog #(
   parameter int NUM_STAGES = 3,
   parameter int CNT_W      = 16,
   parameter int BOOT_W     = 16,
   parameter int PULSE_LEN  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        kick,
   input  logic [BOOT_W-1:0]           boot_delay,
   input  logic [NUM_STAGES*CNT_W-1:0] stage_interval,
   output logic [NUM_STAGES-1:0]       stage_action,
   output logic                        reset_pulse
);
   if (NUM_STAGES < 1 || CNT_W < 1 || BOOT_W < 1 || PULSE_LEN < 1) begin : g_bad_cfg
      $error("escalation_watchdog: every size parameter must be at least 1");
   end

   logic armed;
   logic last_fire;

   wdg_boot_gate #(.BOOT_W(BOOT_W)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .delay   (boot_delay),
      .enabled (armed)
   );

   wdg_stage_seq #(.NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (armed),
      .kick       (kick),
      .intervals  (stage_interval),
      .action     (stage_action),
      .final_fire (last_fire)
   );

   wdg_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (last_fire),
      .pulse (reset_pulse)
   );

   // R8: at most one pulse per escalation
   logic pulse_seen_q, pulse_d_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_seen_q <= 1'b0;
         pulse_d_q    <= 1'b0;
      end else begin
         pulse_d_q <= reset_pulse;
         if (reset_pulse && !pulse_d_q) pulse_seen_q <= 1'b1;
      end
   end

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_seen_q && !pulse_d_q) |-> !reset_pulse);

   // R1: nothing escalates before the boot gate arms
   assert_no_action_unarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (stage_action == '0 && !reset_pulse));

   // R8: the pulse coincides with the final action being set
   assert_pulse_with_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reset_pulse |-> stage_action[NUM_STAGES-1]);
endmodule

// File: tb/escalation_watchdog_tb.sv
`timescale 1ns/1ps
module escalation_watchdog_tb;
   localparam int NS = 3;
   localparam int CW = 8;
   localparam int BW = 8;
   localparam int PL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic kick = 1'b0;
   logic [BW-1:0] boot_delay = '0;
   logic [CW-1:0] iv [NS];
   logic [NS*CW-1:0] iv_flat;
   logic [NS-1:0] act;
   logic pulse;

   always_comb begin
      for (int k = 0; k < NS; k++) iv_flat[k*CW +: CW] = iv[k];
   end

   always #2.5 clk = ~clk;

   escalation_watchdog #(.NUM_STAGES(NS), .CNT_W(CW), .BOOT_W(BW), .PULSE_LEN(PL)) u_dut (
      .clk(clk), .rst_n(rst_n), .kick(kick), .boot_delay(boot_delay),
      .stage_interval(iv_flat), .stage_action(act), .reset_pulse(pulse)
   );

   int checks = 0;
   int failures = 0;
   string tag = "R1";
   bit finished = 0;

   // behavioural reference: edges since release, phase, stage, remaining cycles
   int edge_no = 0;
   int m_phase = 0;   // 0 waiting, 1 counting, 2 finished
   int m_stage = 0;
   int m_left = 0;
   bit [NS-1:0] m_act = '0;
   int m_pulse_left = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         edge_no = 0; m_phase = 0; m_stage = 0; m_left = 0; m_act = '0; m_pulse_left = 0;
      end else begin
         bit fired;
         fired = 0;
         edge_no++;
         if (m_phase == 0) begin
            if (edge_no >= int'(boot_delay) + 2) begin
               m_phase = 1; m_stage = 0; m_left = int'(iv[0]);
            end
         end else if (m_phase == 1) begin
            if (m_stage == 0 && kick) m_left = int'(iv[0]);
            else if (m_left == 0) begin
               m_act[m_stage] = 1'b1;
               if (m_stage == NS - 1) begin
                  m_phase = 2; fired = 1;
               end else begin
                  m_stage++; m_left = int'(iv[m_stage]);
               end
            end else m_left--;
         end
         if (m_pulse_left > 0) m_pulse_left--;
         if (fired) m_pulse_left = PL;
      end
   end

   // per-cycle comparison and event recording
   int first_edge [NS];
   int pulse_cycles = 0;
   int pulse_rises = 0;
   bit pulse_prev = 0;

   always @(negedge clk) begin
      if (!finished) begin
         checks++;
         if (act !== m_act || pulse !== (m_pulse_left > 0)) begin
            failures++;
            $display("FAIL %s cycle compare: actual act=%b pulse=%b expected act=%b pulse=%b",
                     tag, act, pulse, m_act, (m_pulse_left > 0));
         end
         for (int k = 0; k < NS; k++)
            if (act[k] === 1'b1 && first_edge[k] < 0) first_edge[k] = edge_no;
         if (pulse === 1'b1) pulse_cycles++;
         if (pulse === 1'b1 && !pulse_prev) pulse_rises++;
         pulse_prev = (pulse === 1'b1);
      end
   end

   task automatic check_int(string req, string what, int actual, int expected);
      checks++;
      if (actual != expected) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
      end
   endtask

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_kick();
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
   endtask

   task automatic restart(int d, int i0, int i1, int i2);
      @(negedge clk);
      rst_n = 1'b0;
      boot_delay = BW'(d);
      iv[0] = CW'(i0); iv[1] = CW'(i1); iv[2] = CW'(i2);
      cycles(2);
      for (int k = 0; k < NS; k++) first_edge[k] = -1;
      pulse_cycles = 0; pulse_rises = 0; pulse_prev = 0;
      rst_n = 1'b1;
   endtask

   task automatic summary();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   int wd_cycles = 0;
   always @(posedge clk) begin
      wd_cycles++;
      if (wd_cycles > 20000 && !finished) begin
         failures++;
         $display("FAIL watchdog: actual=expired expected=completion");
         summary();
      end
   end

   initial begin
      iv[0] = 8'd5; iv[1] = 8'd4; iv[2] = 8'd6;
      for (int k = 0; k < NS; k++) first_edge[k] = -1;
      cycles(3);
      tag = "R1";
      check_int("R1", "action during reset", int'(act), 0);
      check_int("R1", "pulse during reset", int'(pulse), 0);

      // Scenario A: D=3, intervals 5/4/6, kicks during boot and stage 1
      restart(3, 5, 4, 6);
      tag = "R2";
      cycles(1); pulse_kick(); cycles(1); pulse_kick();
      check_int("R1", "action before arming", int'(act), 0);
      tag = "R3";
      while (first_edge[0] < 0) @(negedge clk);
      check_int("R2", "stage0 timeout edge after boot-time kicks", first_edge[0], 11);
      tag = "R9";
      iv[1] = 8'd50;
      tag = "R6";
      pulse_kick(); cycles(1); pulse_kick();
      while (first_edge[1] < 0) @(negedge clk);
      check_int("R5", "stage1 timeout edge", first_edge[1], 16);
      check_int("R9", "stage1 kept its sampled interval", first_edge[1], 16);
      check_int("R6", "kicks in stage 1 ignored", first_edge[1] - first_edge[0], 5);
      tag = "R8";
      pulse_kick();
      while (first_edge[2] < 0) @(negedge clk);
      check_int("R3", "stage2 timeout edge", first_edge[2], 23);
      cycles(30);
      check_int("R8", "pulse width", pulse_cycles, PL);
      check_int("R8", "pulse count", pulse_rises, 1);
      check_int("R7", "all actions held", int'(act), 7);

      // Scenario B: kicks keep stage 0 alive, including on a zero count
      restart(2, 5, 3, 2);
      iv[1] = 8'd3;
      tag = "R4";
      cycles(4);
      for (int n = 0; n < 15; n++) begin pulse_kick(); cycles(2); end
      check_int("R4", "no timeout under periodic kicks", int'(act), 0);
      for (int n = 0; n < 8; n++) begin pulse_kick(); cycles(5); end
      check_int("R4", "kick on zero count rescues", int'(act), 0);
      tag = "R7";
      cycles(30);
      for (int n = 0; n < 5; n++) begin pulse_kick(); cycles(1); end
      check_int("R7", "actions sticky despite kicks", int'(act), 7);
      check_int("R8", "single pulse in scenario B", pulse_rises, 1);

      // Scenario C: zero-length intervals with no boot delay
      restart(0, 0, 0, 0);
      tag = "R10";
      cycles(12);
      check_int("R10", "stage0 edge", first_edge[0], 3);
      check_int("R10", "stage1 edge", first_edge[1], 4);
      check_int("R10", "stage2 edge", first_edge[2], 5);
      check_int("R8", "pulse width zero intervals", pulse_cycles, PL);

      // Scenario D: reset in the middle of an escalation
      restart(1, 2, 20, 3);
      tag = "R1";
      while (first_edge[0] < 0) @(negedge clk);
      cycles(3);
      rst_n = 1'b0;
      cycles(1);
      check_int("R1", "reset clears actions", int'(act), 0);
      check_int("R1", "reset clears pulse", int'(pulse), 0);
      rst_n = 1'b1;
      cycles(3);
      check_int("R2", "still waiting after re-release", int'(act), 0);
      cycles(10);

      summary();
   end
endmodule